// File: doc/BRIEF.md
# Virtual Group-0 End-of-Interrupt Controller

This block sits in a CPU interface and completes virtual Group-0 interrupts. An acknowledge port reports each interrupt handed to software, along with its ID and priority. Software later writes an end-of-interrupt (EOI) word. Before that write reaches any state, a fixed-order access check looks at the current exception level and a set of control bits. The check makes one of four choices: the write is undefined, it traps to a higher level with a syndrome, it is taken as a virtual EOI, or it is forwarded to the physical EOI path.

A virtual EOI works against a stack of active priorities and a small set of active interrupt IDs. A split-EOI mode bit decides what the EOI does. With the bit clear, the EOI drops the running priority and also deactivates the interrupt. With the bit set, the EOI only drops the priority, and a separate deactivate port retires the interrupt later. Every result is registered and appears one clock after the strobe that caused it.

Top module: `vg0_eoi_ctrl`

## Requirements
- R1: After reset, `run_prio` is 0xFF, `act_cnt` is 0 and every pulse output is low.
- R2: An acknowledge pushes its priority onto the stack and marks its masked ID active. One cycle later, `run_prio` shows that priority and `act_cnt` has gone up by one. The acknowledge is taken only when four conditions hold: the ID is not special, the stack is not full, the ID is not already active, and no EOI strobe arrives in the same cycle.
- R3: An acknowledge of a special ID (1020 to 1023) is ignored. It pushes nothing and does not count as a valid acknowledge.
- R4: A virtual EOI is valid when its ID equals the ID on top of the stack. With `split_eoi`=0, a valid EOI has three effects: it pulses `virt_drop`, it pops the stack so that `run_prio` becomes the new top or 0xFF, and it deactivates the ID, which shows as `deact_vld` with `deact_id` and `act_cnt` going down by one.
- R5: With `split_eoi`=1, a valid EOI only pops the stack. The ID stays active until a deactivate write names it, and that write pulses `deact_vld` and lowers `act_cnt`.
- R6: A virtual EOI whose ID does not match the top of the stack, or that arrives with an empty stack, pulses `eoi_err` and changes neither `run_prio` nor `act_cnt`.
- R7: A deactivate write naming an ID that is not active pulses `dir_err` and has no other effect.
- R8: The ID is taken from bits [23:0] of the 64-bit word, and bits [63:24] are ignored. With `ID_BITS`=16 (the default), bits [23:16] are also ignored on acknowledge, EOI and deactivate.
- R9: An EOI write at level 0 (`cur_el`=0) pulses `acc_undef` and changes no state.
- R10: At level 1 the checks run in this order, and the first one that applies decides the outcome:
  - `sre_el1`=0 traps to level 1.
  - `el2_on` with `el2_trap_g0` traps to level 2.
  - `el2_on` with `el2_fiq_virt` takes the virtual EOI path.
  - `el3_on` with `el3_fiq` traps to level 3.
  - Otherwise the write goes to the physical path, pulsing `phys_wr` with `phys_id`.
- R11: At level 2, `sre_el2`=0 traps to 2, otherwise `el3_on` with `el3_fiq` traps to 3, otherwise the write goes physical. At level 3, `sre_el3`=0 traps to 3, otherwise the write goes physical. A write that traps or goes physical changes no virtual state.
- R12: A trap pulses `acc_trap`, and `trap_lvl` carries the target level encoded as 1, 2 or 3. `trap_syn` carries class 0x18. At most one of undefined, trap, physical and virtual outcomes occurs per write.
- R13: With `DEPTH` (8) entries on the stack, a further acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 24 | Acknowledged interrupt ID |
| ack_prio | input | PRIO_W | Priority of acknowledged interrupt |
| eoi_valid | input | 1 | EOI write strobe |
| eoi_data | input | 64 | EOI write word |
| dir_valid | input | 1 | Deactivate write strobe |
| dir_data | input | 64 | Deactivate write word |
| split_eoi | input | 1 | Split mode: EOI drops priority only |
| cur_el | input | 2 | Exception level of the writer |
| sre_el1 | input | 1 | Register interface enable, level 1 |
| sre_el2 | input | 1 | Register interface enable, level 2 |
| sre_el3 | input | 1 | Register interface enable, level 3 |
| el2_on | input | 1 | Level 2 enabled and 64-bit |
| el2_trap_g0 | input | 1 | Level 2 traps all Group-0 accesses |
| el2_fiq_virt | input | 1 | Level 2 routes FIQ, so EOIs go virtual |
| el3_on | input | 1 | Level 3 present and 64-bit |
| el3_fiq | input | 1 | Level 3 claims FIQ |
| acc_undef | output | 1 | Write was undefined |
| acc_trap | output | 1 | Write trapped |
| trap_lvl | output | 2 | Trap target level |
| trap_syn | output | 6 | Trap syndrome class |
| phys_wr | output | 1 | Write forwarded to the physical path |
| phys_id | output | 24 | ID of the forwarded write |
| virt_drop | output | 1 | Valid virtual EOI, priority dropped |
| eoi_err | output | 1 | Virtual EOI did not match |
| deact_vld | output | 1 | An interrupt was deactivated |
| deact_id | output | 24 | ID deactivated |
| dir_err | output | 1 | Deactivate named an inactive ID |
| run_prio | output | PRIO_W | Running priority, all ones when idle |
| act_cnt | output | $clog2(DEPTH+1) | Number of active IDs |

## Verification
A corrupt stack pointer or stack entry shows on `run_prio` in the cycle after the acknowledge or EOI that exposes it. It also shows on the next EOI, which pulses `eoi_err` instead of `virt_drop`. A wrong active set shows at `act_cnt` right away. It shows again later, when a deactivate write raises `dir_err` unexpectedly, or when an acknowledge is refused without reason. Routing faults show on the pulse outputs one cycle after the strobe. Traps and physical writes are checked to leave `run_prio` and `act_cnt` untouched, which catches a trapped write that leaks into the virtual state.

// File: rtl/vg0_eoi_ctrl.sv
module vg0_eoi_ctrl #(
  parameter int DEPTH   = 8,
  parameter int ID_BITS = 16,
  parameter int PRIO_W  = 8,
  localparam int SP_W   = $clog2(DEPTH + 1),
  localparam int IX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_valid,
  input  logic [23:0]       ack_id,
  input  logic [PRIO_W-1:0] ack_prio,
  input  logic              eoi_valid,
  input  logic [63:0]       eoi_data,
  input  logic              dir_valid,
  input  logic [63:0]       dir_data,
  input  logic              split_eoi,
  input  logic [1:0]        cur_el,
  input  logic              sre_el1,
  input  logic              sre_el2,
  input  logic              sre_el3,
  input  logic              el2_on,
  input  logic              el2_trap_g0,
  input  logic              el2_fiq_virt,
  input  logic              el3_on,
  input  logic              el3_fiq,
  output logic              acc_undef,
  output logic              acc_trap,
  output logic [1:0]        trap_lvl,
  output logic [5:0]        trap_syn,
  output logic              phys_wr,
  output logic [23:0]       phys_id,
  output logic              virt_drop,
  output logic              eoi_err,
  output logic              deact_vld,
  output logic [23:0]       deact_id,
  output logic              dir_err,
  output logic [PRIO_W-1:0] run_prio,
  output logic [SP_W-1:0]   act_cnt
);

  localparam logic [23:0] ID_MASK = (ID_BITS >= 24) ? 24'hFF_FFFF : 24'h00_FFFF;
  localparam logic [5:0]  TRAP_EC = 6'h18;

  typedef enum logic [2:0] {RT_NONE, RT_UNDEF, RT_TRAP, RT_VIRT, RT_PHYS} route_e;

  logic [PRIO_W-1:0] stk_prio [DEPTH];
  logic [23:0]       stk_id   [DEPTH];
  logic [SP_W-1:0]   sp;
  logic [DEPTH-1:0]  act_vld;
  logic [23:0]       act_id   [DEPTH];

  logic [23:0] e_id, d_id, a_id;
  logic        unused_hi;
  assign e_id = eoi_data[23:0] & ID_MASK;
  assign d_id = dir_data[23:0] & ID_MASK;
  assign a_id = ack_id & ID_MASK;
  assign unused_hi = ^{eoi_data[63:24], dir_data[63:24]};

  route_e     rt;
  logic [1:0] tl;

  always_comb begin
    rt = RT_NONE;
    tl = 2'd0;
    if (eoi_valid) begin
      case (cur_el)
        2'd0: rt = RT_UNDEF;
        2'd1:
          if (!sre_el1)                     begin rt = RT_TRAP; tl = 2'd1; end
          else if (el2_on && el2_trap_g0)   begin rt = RT_TRAP; tl = 2'd2; end
          else if (el2_on && el2_fiq_virt)  rt = RT_VIRT;
          else if (el3_on && el3_fiq)       begin rt = RT_TRAP; tl = 2'd3; end
          else                              rt = RT_PHYS;
        2'd2:
          if (!sre_el2)                     begin rt = RT_TRAP; tl = 2'd2; end
          else if (el3_on && el3_fiq)       begin rt = RT_TRAP; tl = 2'd3; end
          else                              rt = RT_PHYS;
        default:
          if (!sre_el3)                     begin rt = RT_TRAP; tl = 2'd3; end
          else                              rt = RT_PHYS;
      endcase
    end
  end

  logic [IX_W-1:0] top_i, push_i, free_i;
  logic            stk_empty, stk_full;
  assign stk_empty = (sp == '0);
  assign stk_full  = (sp == SP_W'(DEPTH));
  assign top_i     = IX_W'(sp - 1'b1);
  assign push_i    = IX_W'(sp);

  logic [DEPTH-1:0] hit_e, hit_d, hit_a;
  logic             have_free;

  always_comb begin
    have_free = 1'b0;
    free_i    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_e[i] = act_vld[i] && (act_id[i] == e_id);
      hit_d[i] = act_vld[i] && (act_id[i] == d_id);
      hit_a[i] = act_vld[i] && (act_id[i] == a_id);
      if (!act_vld[i] && !have_free) begin
        have_free = 1'b1;
        free_i    = IX_W'(i);
      end
    end
  end

  logic special, ack_ok, eoi_hit, eoi_miss, dir_hit, eoi_deact;
  assign special   = (a_id >= 24'd1020) && (a_id <= 24'd1023);
  assign ack_ok    = ack_valid && !eoi_valid && !special && !stk_full && !(|hit_a) && have_free;
  assign eoi_hit   = (rt == RT_VIRT) && !stk_empty && (stk_id[top_i] == e_id);
  assign eoi_miss  = (rt == RT_VIRT) && !eoi_hit;
  assign eoi_deact = eoi_hit && !split_eoi;
  assign dir_hit   = dir_valid && (|hit_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp      <= '0;
      act_vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stk_prio[i] <= '0;
        stk_id[i]   <= '0;
        act_id[i]   <= '0;
      end
    end else begin
      if (eoi_hit) begin
        sp <= sp - 1'b1;
      end else if (ack_ok) begin
        stk_prio[push_i] <= ack_prio;
        stk_id[push_i]   <= a_id;
        sp               <= sp + 1'b1;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if ((eoi_deact && hit_e[i]) || (dir_valid && hit_d[i])) begin
          act_vld[i] <= 1'b0;
        end else if (ack_ok && (free_i == IX_W'(i))) begin
          act_vld[i] <= 1'b1;
          act_id[i]  <= a_id;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_undef <= 1'b0;
      acc_trap  <= 1'b0;
      trap_lvl  <= '0;
      trap_syn  <= '0;
      phys_wr   <= 1'b0;
      phys_id   <= '0;
      virt_drop <= 1'b0;
      eoi_err   <= 1'b0;
      deact_vld <= 1'b0;
      deact_id  <= '0;
      dir_err   <= 1'b0;
    end else begin
      acc_undef <= (rt == RT_UNDEF);
      acc_trap  <= (rt == RT_TRAP);
      trap_lvl  <= (rt == RT_TRAP) ? tl : 2'd0;
      trap_syn  <= (rt == RT_TRAP) ? TRAP_EC : 6'd0;
      phys_wr   <= (rt == RT_PHYS);
      phys_id   <= (rt == RT_PHYS) ? e_id : 24'd0;
      virt_drop <= eoi_hit;
      eoi_err   <= eoi_miss;
      deact_vld <= eoi_deact || dir_hit;
      deact_id  <= eoi_deact ? e_id : (dir_hit ? d_id : 24'd0);
      dir_err   <= dir_valid && !dir_hit;
    end
  end

  assign run_prio = stk_empty ? {PRIO_W{1'b1}} : stk_prio[top_i];
  assign act_cnt  = SP_W'($countones(act_vld));

  a_r13_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(DEPTH));

  a_r9_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && cur_el == 2'd0) |=> acc_undef);

  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_undef, acc_trap, phys_wr, virt_drop | eoi_err}));

  a_r12_trap_fields: assert property (@(posedge clk) disable iff (!rst_n)
    acc_trap |-> (trap_syn == 6'h18 && trap_lvl != 2'd0));

  a_r6_miss_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_err && !$past(dir_valid)) |-> (sp == $past(sp) && act_vld == $past(act_vld)));

  a_r4_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    virt_drop |-> (sp == $past(sp) - 1'b1));

  a_r5_split_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    (virt_drop && $past(split_eoi) && !$past(dir_valid)) |-> !deact_vld);

endmodule

// File: tb/vg0_eoi_ctrl_bench.sv
`timescale 1ns/1ps
module vg0_eoi_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ack_valid = 0; logic [23:0] ack_id = 0; logic [7:0] ack_prio = 0;
  logic eoi_valid = 0; logic [63:0] eoi_data = 0;
  logic dir_valid = 0; logic [63:0] dir_data = 0;
  logic split_eoi = 0; logic [1:0] cur_el = 2'd1;
  logic sre_el1 = 1, sre_el2 = 1, sre_el3 = 1, el2_on = 1, el2_trap_g0 = 0;
  logic el2_fiq_virt = 1, el3_on = 1, el3_fiq = 0;
  logic acc_undef, acc_trap, phys_wr, virt_drop, eoi_err, deact_vld, dir_err;
  logic [1:0] trap_lvl; logic [5:0] trap_syn; logic [23:0] phys_id, deact_id;
  logic [7:0] run_prio; logic [3:0] act_cnt;
  int n_chk = 0, n_fail = 0; bit done = 0;

  always #4 clk = ~clk;

  vg0_eoi_ctrl u_vg0_eoi_ctrl (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] el, input logic s1, s2, s3, e2, tg, fv, e3, fq);
    cur_el = el; sre_el1 = s1; sre_el2 = s2; sre_el3 = s3;
    el2_on = e2; el2_trap_g0 = tg; el2_fiq_virt = fv; el3_on = e3; el3_fiq = fq;
  endtask

  task automatic do_ack(input logic [23:0] id, input logic [7:0] pr);
    @(negedge clk); ack_valid = 1; ack_id = id; ack_prio = pr;
    @(negedge clk); ack_valid = 0;
  endtask

  task automatic do_eoi(input logic [63:0] d, input logic sp);
    @(negedge clk); eoi_valid = 1; eoi_data = d; split_eoi = sp;
    @(negedge clk); eoi_valid = 0;
  endtask

  task automatic do_dir(input logic [63:0] d);
    @(negedge clk); dir_valid = 1; dir_data = d;
    @(negedge clk); dir_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1", "run_prio", run_prio, 8'hFF);
    chk("R1", "act_cnt", act_cnt, 0);
    chk("R1", "pulses", {acc_undef, acc_trap, phys_wr, virt_drop, eoi_err, deact_vld, dir_err}, 0);
  endtask

  task automatic t_ack;
    do_ack(24'h770020, 8'h40);
    chk("R2", "run_prio after ack 32", run_prio, 8'h40);
    chk("R2", "act_cnt", act_cnt, 1);
    do_ack(24'd33, 8'h20);
    chk("R2", "run_prio after ack 33", run_prio, 8'h20);
    chk("R2", "act_cnt", act_cnt, 2);
    do_ack(24'd1021, 8'h10);
    chk("R3", "special ack run_prio", run_prio, 8'h20);
    chk("R3", "special ack act_cnt", act_cnt, 2);
  endtask

  task automatic t_mismatch;
    cfg(2'd1, 1, 1, 1, 1, 0, 1, 1, 0);
    do_eoi(64'd32, 1'b0);
    chk("R6", "eoi_err", eoi_err, 1);
    chk("R6", "virt_drop", virt_drop, 0);
    chk("R6", "run_prio", run_prio, 8'h20);
    chk("R6", "act_cnt", act_cnt, 2);
  endtask

  task automatic t_eoi_mode0;
    do_eoi({40'hA5A5A5A5A5, 8'hAB, 16'h0021}, 1'b0);
    chk("R8", "masked id matched", virt_drop, 1);
    chk("R4", "deact_vld", deact_vld, 1);
    chk("R4", "deact_id", deact_id, 24'd33);
    chk("R4", "run_prio", run_prio, 8'h40);
    chk("R4", "act_cnt", act_cnt, 1);
  endtask

  task automatic t_split;
    do_eoi(64'd32, 1'b1);
    chk("R5", "virt_drop", virt_drop, 1);
    chk("R5", "no deact", deact_vld, 0);
    chk("R5", "run_prio idle", run_prio, 8'hFF);
    chk("R5", "still active", act_cnt, 1);
    do_eoi(64'd32, 1'b1);
    chk("R6", "empty stack eoi_err", eoi_err, 1);
    chk("R6", "act_cnt", act_cnt, 1);
    do_dir({40'h0, 8'h5C, 16'd32});
    chk("R5", "dir deact_vld", deact_vld, 1);
    chk("R5", "dir deact_id", deact_id, 24'd32);
    chk("R5", "dir act_cnt", act_cnt, 0);
    do_dir(64'd32);
    chk("R7", "dir_err", dir_err, 1);
    chk("R7", "no deact", deact_vld, 0);
    chk("R7", "act_cnt", act_cnt, 0);
    chk("R7", "run_prio", run_prio, 8'hFF);
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) do_ack(24'(100 + i), 8'(8'h80 - 4 * i));
    chk("R2", "eight acks run_prio", run_prio, 8'h64);
    chk("R2", "eight acks act_cnt", act_cnt, 8);
    do_ack(24'd200, 8'h01);
    chk("R13", "full ack ignored run_prio", run_prio, 8'h64);
    chk("R13", "full ack ignored act_cnt", act_cnt, 8);
    do_eoi(64'd107, 1'b0);
    chk("R4", "pop to 106 prio", run_prio, 8'h68);
    for (int i = 6; i >= 0; i--) do_eoi(64'(100 + i), 1'b0);
    chk("R4", "drained run_prio", run_prio, 8'hFF);
    chk("R4", "drained act_cnt", act_cnt, 0);
  endtask

  task automatic route(input string req, input int kind, input logic [1:0] lvl);
    do_eoi(64'd5, 1'b0);
    chk(req, "undef", acc_undef, kind == 0);
    chk(req, "trap", acc_trap, kind == 1);
    chk(req, "trap_lvl", trap_lvl, (kind == 1) ? lvl : 2'd0);
    if (kind == 1) chk("R12", "syndrome", trap_syn, 6'h18);
    chk(req, "phys", phys_wr, kind == 2);
    if (kind == 2) chk(req, "phys_id", phys_id, 24'd5);
    chk(req, "virt", virt_drop | eoi_err, kind == 3);
    if (kind != 3) chk("R11", "state kept", {run_prio, act_cnt}, {8'h30, 4'd1});
  endtask

  task automatic t_route;
    do_ack(24'd5, 8'h30);
    cfg(2'd0, 1, 1, 1, 1, 0, 1, 1, 0); route("R9", 0, 0);
    cfg(2'd1, 0, 1, 1, 1, 1, 1, 1, 1); route("R10", 1, 2'd1);
    cfg(2'd1, 1, 1, 1, 1, 1, 1, 1, 1); route("R10", 1, 2'd2);
    cfg(2'd1, 1, 1, 1, 0, 1, 1, 1, 1); route("R10", 1, 2'd3);
    cfg(2'd1, 1, 1, 1, 0, 0, 1, 1, 0); route("R10", 2, 0);
    cfg(2'd2, 1, 0, 1, 1, 0, 1, 1, 1); route("R11", 1, 2'd2);
    cfg(2'd2, 1, 1, 1, 1, 0, 1, 1, 1); route("R11", 1, 2'd3);
    cfg(2'd2, 1, 1, 1, 1, 0, 1, 0, 1); route("R11", 2, 0);
    cfg(2'd3, 1, 1, 0, 1, 0, 1, 1, 1); route("R11", 1, 2'd3);
    cfg(2'd3, 1, 1, 1, 1, 0, 1, 1, 1); route("R11", 2, 0);
    cfg(2'd1, 1, 1, 1, 1, 0, 1, 1, 1); route("R10", 3, 0);
    chk("R10", "virtual EOI popped", run_prio, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ack;
    t_mismatch;
    t_eoi_mode0;
    t_split;
    t_full;
    t_route;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule